// File: doc/BRIEF.md
# Endpoint Register Bring-Up Sequencer

This controller configures one serial-interconnect endpoint after reset. It needs no processor. On a start pulse it acts as a 32-bit memory-mapped master. It polls the endpoint's port status register until the link reports ready. It then writes, in a fixed order:

- the endpoint's own device ID;
- the request-issue enable in the port control register, using read-modify-write;
- the destination ID of outgoing maintenance window 0;
- that window's enable bit.

The own ID, the destination ID and the 8-bit or 16-bit ID layout are parameters. Two instances, one set to own 0x01 / destination 0x02 and the other to own 0x02 / destination 0x00, bring up a pair of endpoints that can reach each other.

The master side follows memory-mapped back-pressure rules. While `mm_waitrequest` is high, the pending strobe, address and write data stay unchanged. A read result is taken only in the cycle `mm_readdatavalid` is high, and the value on `mm_readdata` at any other time is ignored. One access is in flight at a time. The `start`, `busy`, `done` and `error` pins are plain levels and pulses.

Top module: `ep_bringup_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `mm_read` and `mm_write` are all 0.
- R2: The first access after start is a read of byte offset 0x158. The read repeats until bit `LINK_OK_BIT` (default 1) of the returned word is 1, and no write is issued before that read returns.
- R3: If `MAX_POLLS` status reads in a row return the ready bit clear, the sequencer issues no write, drops `busy` and holds `error` at 1.
- R4: The own-ID write goes to offset 0x060. Its data is `{8'h00, OWN_ID[7:0], 16'h0000}` when `WIDE_ID`=0 and `{16'h0000, OWN_ID[15:0]}` when `WIDE_ID`=1.
- R5: The control register at offset 0x13C is read once, then written back with bit 30 set and every other bit unchanged.
- R6: The window-0 control write goes to offset 0x1010C. Its data is `{8'h00, DEST_ID[7:0], 16'h0000}` when `WIDE_ID`=0 and `{DEST_ID[15:0], 16'h0000}` when `WIDE_ID`=1, with the upper ID byte in bits 31:24.
- R7: The window-0 mask write goes to offset 0x10104 with data 0x00000004, which sets the enable in bit 2.
- R8: After the status check, exactly four writes occur, to offsets 0x060, 0x13C, 0x1010C and 0x10104 in that order.
- R9: While `mm_waitrequest` is 1, an asserted strobe, its address and its write data stay unchanged. A read value is taken only when `mm_readdatavalid` is 1.
- R10: `done` rises after the last write is accepted and stays 1 until the next start. A start pulse while `busy` is 1 has no effect.
- R11: `mm_byteenable` is 4'hF whenever a strobe is asserted, and `mm_read` and `mm_write` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins the sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished; held until the next start |
| error | output | 1 | Link never reported ready; held until the next start |
| mm_address | output | ADDR_W | Byte offset of the current access |
| mm_read | output | 1 | Read strobe |
| mm_write | output | 1 | Write strobe |
| mm_writedata | output | 32 | Write data |
| mm_byteenable | output | 4 | Byte lanes, always all set |
| mm_waitrequest | input | 1 | Slave stall; holds the current access |
| mm_readdata | input | 32 | Read data |
| mm_readdatavalid | input | 1 | Marks the cycle in which `mm_readdata` is valid |

## Verification
Runs are driven from a vector table. The rows vary three things: the number of not-ready status replies before ready, the stall length on every access, and the starting value of the control register (zero, all ones, sparse bits). Counting status reads and the position of the first write separates correct polling from early writes and miscounted retries. A run that never reaches ready separates the error path from a sequencer that gives up one read early or one read late. Three instances (narrow 0x01/0x02, narrow 0x02/0x00, and wide with distinct upper and lower bytes) show whether the ID bytes land in the right field. The slave model drives a junk word whenever read data is not valid, which exposes any capture taken outside `mm_readdatavalid`.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL,
    ST_WR_ID,
    ST_CTL_RD,
    ST_WR_CTL,
    ST_WR_WIN,
    ST_WR_MASK,
    ST_DONE,
    ST_ERR
  } seq_state_t;

  localparam logic [31:0] OFS_PORT_STATUS = 32'h0000_0158;
  localparam logic [31:0] OFS_DEVICE_ID   = 32'h0000_0060;
  localparam logic [31:0] OFS_PORT_CTL    = 32'h0000_013C;
  localparam logic [31:0] OFS_WIN0_CTL    = 32'h0001_010C;
  localparam logic [31:0] OFS_WIN0_MASK   = 32'h0001_0104;

  localparam int CTL_REQ_EN_BIT = 30;
  localparam int WIN_EN_BIT     = 2;

endpackage

// File: rtl/bringup_step_decode.sv
module bringup_step_decode
  import bringup_pkg::*;
#(
  parameter int          ADDR_W  = 20,
  parameter bit          WIDE_ID = 1'b0,
  parameter logic [15:0] OWN_ID  = 16'h0001,
  parameter logic [15:0] DEST_ID = 16'h0002
) (
  input  seq_state_t        state,
  input  logic [31:0]       ctl_val,
  output logic              access,
  output logic              is_wr,
  output logic [ADDR_W-1:0] addr,
  output logic [31:0]       wdata
);

  localparam logic [31:0] ID_WORD = WIDE_ID ? {16'h0000, OWN_ID}
                                            : {8'h00, OWN_ID[7:0], 16'h0000};
  localparam logic [31:0] WIN_WORD = WIDE_ID ? {DEST_ID, 16'h0000}
                                             : {8'h00, DEST_ID[7:0], 16'h0000};
  localparam logic [31:0] CTL_SET  = 32'(1) << CTL_REQ_EN_BIT;
  localparam logic [31:0] MASK_WORD = 32'(1) << WIN_EN_BIT;

  always_comb begin
    access = 1'b1;
    is_wr  = 1'b1;
    addr   = '0;
    wdata  = '0;
    unique case (state)
      ST_POLL: begin
        is_wr = 1'b0;
        addr  = ADDR_W'(OFS_PORT_STATUS);
      end
      ST_WR_ID: begin
        addr  = ADDR_W'(OFS_DEVICE_ID);
        wdata = ID_WORD;
      end
      ST_CTL_RD: begin
        is_wr = 1'b0;
        addr  = ADDR_W'(OFS_PORT_CTL);
      end
      ST_WR_CTL: begin
        addr  = ADDR_W'(OFS_PORT_CTL);
        wdata = ctl_val | CTL_SET;
      end
      ST_WR_WIN: begin
        addr  = ADDR_W'(OFS_WIN0_CTL);
        wdata = WIN_WORD;
      end
      ST_WR_MASK: begin
        addr  = ADDR_W'(OFS_WIN0_MASK);
        wdata = MASK_WORD;
      end
      default: begin
        access = 1'b0;
        is_wr  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/bringup_mm_port.sv
module bringup_mm_port #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              fin,
  output logic [31:0]       rdata,
  output logic [ADDR_W-1:0] mm_address,
  output logic              mm_read,
  output logic              mm_write,
  output logic [31:0]       mm_writedata,
  input  logic              mm_waitrequest,
  input  logic [31:0]       mm_readdata,
  input  logic              mm_readdatavalid
);

  typedef enum logic [1:0] {P_IDLE, P_ISSUE, P_RWAIT} port_state_t;
  port_state_t pst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst          <= P_IDLE;
      mm_address   <= '0;
      mm_read      <= 1'b0;
      mm_write     <= 1'b0;
      mm_writedata <= '0;
      rdata        <= '0;
      fin          <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (pst)
        P_IDLE: if (req) begin
          mm_address   <= req_addr;
          mm_writedata <= req_wdata;
          mm_write     <= req_wr;
          mm_read      <= !req_wr;
          pst          <= P_ISSUE;
        end
        P_ISSUE: if (!mm_waitrequest) begin
          mm_read  <= 1'b0;
          mm_write <= 1'b0;
          if (mm_write) begin
            fin <= 1'b1;
            pst <= P_IDLE;
          end else begin
            pst <= P_RWAIT;
          end
        end
        P_RWAIT: if (mm_readdatavalid) begin
          rdata <= mm_readdata;
          fin   <= 1'b1;
          pst   <= P_IDLE;
        end
        default: pst <= P_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bringup_poll_ctr.sv
module bringup_poll_ctr #(
  parameter int MAX_POLLS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic miss,
  output logic exhausted
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLLS - 1);

  logic [CNT_W-1:0] misses;

  assign exhausted = miss && (misses == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) misses <= '0;
    else if (miss)     misses <= misses + 1'b1;
  end

endmodule

// File: rtl/ep_bringup_seq.sv
module ep_bringup_seq
  import bringup_pkg::*;
#(
  parameter int          ADDR_W      = 20,
  parameter bit          WIDE_ID     = 1'b0,
  parameter logic [15:0] OWN_ID      = 16'h0001,
  parameter logic [15:0] DEST_ID     = 16'h0002,
  parameter int          LINK_OK_BIT = 1,
  parameter int          MAX_POLLS   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] mm_address,
  output logic              mm_read,
  output logic              mm_write,
  output logic [31:0]       mm_writedata,
  output logic [3:0]        mm_byteenable,
  input  logic              mm_waitrequest,
  input  logic [31:0]       mm_readdata,
  input  logic              mm_readdatavalid
);

  seq_state_t        state;
  logic              pending;
  logic [31:0]       ctl_val;
  logic              step_access, step_wr;
  logic [ADDR_W-1:0] step_addr;
  logic [31:0]       step_wdata;
  logic              fin;
  logic [31:0]       rdata;
  logic              launch, poll_miss, poll_exhausted;

  assign busy  = !(state inside {ST_IDLE, ST_DONE, ST_ERR});
  assign done  = (state == ST_DONE);
  assign error = (state == ST_ERR);
  assign launch = start && !busy;
  assign mm_byteenable = 4'hF;
  assign poll_miss = (state == ST_POLL) && fin && !rdata[LINK_OK_BIT];

  bringup_step_decode #(
    .ADDR_W(ADDR_W), .WIDE_ID(WIDE_ID), .OWN_ID(OWN_ID), .DEST_ID(DEST_ID)
  ) u_decode (
    .state  (state),
    .ctl_val(ctl_val),
    .access (step_access),
    .is_wr  (step_wr),
    .addr   (step_addr),
    .wdata  (step_wdata)
  );

  bringup_mm_port #(.ADDR_W(ADDR_W)) u_port (
    .clk             (clk),
    .rst_n           (rst_n),
    .req             (step_access && !pending),
    .req_wr          (step_wr),
    .req_addr        (step_addr),
    .req_wdata       (step_wdata),
    .fin             (fin),
    .rdata           (rdata),
    .mm_address      (mm_address),
    .mm_read         (mm_read),
    .mm_write        (mm_write),
    .mm_writedata    (mm_writedata),
    .mm_waitrequest  (mm_waitrequest),
    .mm_readdata     (mm_readdata),
    .mm_readdatavalid(mm_readdatavalid)
  );

  bringup_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_polls (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (launch),
    .miss     (poll_miss),
    .exhausted(poll_exhausted)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      ctl_val <= '0;
    end else if (launch) begin
      state   <= ST_POLL;
      pending <= 1'b0;
    end else begin
      if (pending) pending <= !fin;
      else         pending <= step_access;
      if (fin) begin
        unique case (state)
          ST_POLL: begin
            if (rdata[LINK_OK_BIT]) state <= ST_WR_ID;
            else if (poll_exhausted) state <= ST_ERR;
          end
          ST_WR_ID:   state <= ST_CTL_RD;
          ST_CTL_RD: begin
            ctl_val <= rdata;
            state   <= ST_WR_CTL;
          end
          ST_WR_CTL:  state <= ST_WR_WIN;
          ST_WR_WIN:  state <= ST_WR_MASK;
          ST_WR_MASK: state <= ST_DONE;
          default:    state <= state;
        endcase
      end
    end
  end

endmodule

// File: rtl/bringup_seq_chk.sv
module bringup_seq_chk
  import bringup_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int LINK_OK_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic [ADDR_W-1:0] mm_address,
  input logic              mm_read,
  input logic              mm_write,
  input logic [31:0]       mm_writedata,
  input logic [3:0]        mm_byteenable,
  input logic              mm_waitrequest,
  input logic [31:0]       mm_readdata,
  input logic              mm_readdatavalid
);

  logic status_rd_out, link_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_rd_out <= 1'b0;
      link_seen     <= 1'b0;
    end else begin
      if (start && !busy) link_seen <= 1'b0;
      else if (mm_readdatavalid && status_rd_out && mm_readdata[LINK_OK_BIT])
        link_seen <= 1'b1;
      if (mm_read && !mm_waitrequest)
        status_rd_out <= (mm_address == ADDR_W'(OFS_PORT_STATUS));
      else if (mm_readdatavalid)
        status_rd_out <= 1'b0;
    end
  end

  // R1 reset level
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy && !done && !error && !mm_read && !mm_write);

  p_write_after_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mm_write |-> link_seen);

  p_error_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !mm_write && !busy);

  p_ctl_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_write && mm_address == ADDR_W'(OFS_PORT_CTL)) |-> mm_writedata[CTL_REQ_EN_BIT]);

  p_mask_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_write && mm_address == ADDR_W'(OFS_WIN0_MASK)) |-> mm_writedata == 32'h4);

  p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_read && mm_waitrequest) |=> mm_read && $stable(mm_address));

  p_write_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_write && mm_waitrequest) |=> mm_write && $stable(mm_address) && $stable(mm_writedata));

  p_done_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !error);

  p_done_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_read && mm_write));

  p_full_lanes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_read || mm_write) |-> mm_byteenable == 4'hF);

endmodule

bind ep_bringup_seq bringup_seq_chk #(
  .ADDR_W(ADDR_W), .LINK_OK_BIT(LINK_OK_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .error(error),
  .mm_address(mm_address), .mm_read(mm_read), .mm_write(mm_write),
  .mm_writedata(mm_writedata), .mm_byteenable(mm_byteenable),
  .mm_waitrequest(mm_waitrequest), .mm_readdata(mm_readdata),
  .mm_readdatavalid(mm_readdatavalid)
);

// File: tb/ep_bringup_seq_bench.sv
module bringup_slave_model #(
  parameter int ADDR_W = 20,
  parameter int OK_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [7:0]        ok_after,
  input  logic [3:0]        wait_n,
  input  logic [31:0]       ctl_init,
  input  logic [ADDR_W-1:0] address,
  input  logic              read,
  input  logic              write,
  input  logic [31:0]       writedata,
  input  logic [3:0]        byteenable,
  output logic              waitrequest,
  output logic [31:0]       readdata,
  output logic              readdatavalid
);
  int wcnt, nw, n_stat, n_ctl, first_wr_stat, viol;
  logic [31:0] wa [8];
  logic [31:0] wd [8];
  logic p_stall;
  logic [1:0] p_rw;
  logic [ADDR_W-1:0] p_addr;
  logic [31:0] p_wd;

  assign waitrequest = (read || write) && (wcnt < int'(wait_n));

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      wcnt <= 0; nw <= 0; n_stat <= 0; n_ctl <= 0; first_wr_stat <= -1; viol <= 0;
      p_stall <= 1'b0; readdatavalid <= 1'b0; readdata <= 32'hDEAD_BEEF;
    end else begin
      readdatavalid <= 1'b0;
      readdata <= 32'hDEAD_BEEF;
      if (p_stall && ({read, write} != p_rw || address != p_addr ||
                      (write && writedata != p_wd))) viol <= viol + 1;
      if ((read && write) || ((read || write) && byteenable != 4'hF)) viol <= viol + 1;
      p_stall <= (read || write) && waitrequest;
      p_rw <= {read, write};
      p_addr <= address;
      p_wd <= writedata;
      if ((read || write) && waitrequest) wcnt <= wcnt + 1;
      else if (read || write) begin
        wcnt <= 0;
        if (write) begin
          if (nw < 8) begin
            wa[nw] <= 32'(address);
            wd[nw] <= writedata;
          end
          if (nw == 0) first_wr_stat <= n_stat;
          nw <= nw + 1;
        end else begin
          readdatavalid <= 1'b1;
          if (32'(address) == 32'h158) begin
            readdata <= (n_stat >= int'(ok_after)) ? (32'(1) << OK_BIT)
                                                   : ~(32'(1) << OK_BIT);
            n_stat <= n_stat + 1;
          end else if (32'(address) == 32'h13C) begin
            readdata <= ctl_init;
            n_ctl <= n_ctl + 1;
          end else readdata <= 32'h0;
        end
      end
    end
  end
endmodule

module ep_bringup_seq_bench;
  localparam int ADDR_W = 20;
  localparam int MAXP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic clr = 1'b0;
  logic [7:0] ok_after = 8'd0;
  logic [3:0] wait_n = 4'd0;
  logic [31:0] ctl_init = 32'h0;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  logic [ADDR_W-1:0] a_adr, b_adr, c_adr;
  logic a_rd, a_wr, b_rd, b_wr, c_rd, c_wr;
  logic [31:0] a_wd, b_wd, c_wd, a_rdd, b_rdd, c_rdd;
  logic [3:0] a_be, b_be, c_be;
  logic a_wt, b_wt, c_wt, a_rv, b_rv, c_rv;
  logic a_busy, a_done, a_err, b_busy, b_done, b_err, c_busy, c_done, c_err;

  ep_bringup_seq #(.ADDR_W(ADDR_W), .WIDE_ID(1'b0), .OWN_ID(16'h0001), .DEST_ID(16'h0002),
                   .LINK_OK_BIT(1), .MAX_POLLS(MAXP)) u_ep_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(a_busy), .done(a_done), .error(a_err),
    .mm_address(a_adr), .mm_read(a_rd), .mm_write(a_wr), .mm_writedata(a_wd),
    .mm_byteenable(a_be), .mm_waitrequest(a_wt), .mm_readdata(a_rdd), .mm_readdatavalid(a_rv));
  bringup_slave_model #(.ADDR_W(ADDR_W), .OK_BIT(1)) u_sa (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ok_after(ok_after), .wait_n(wait_n), .ctl_init(ctl_init),
    .address(a_adr), .read(a_rd), .write(a_wr), .writedata(a_wd), .byteenable(a_be),
    .waitrequest(a_wt), .readdata(a_rdd), .readdatavalid(a_rv));

  ep_bringup_seq #(.ADDR_W(ADDR_W), .WIDE_ID(1'b0), .OWN_ID(16'h0002), .DEST_ID(16'h0000),
                   .LINK_OK_BIT(1), .MAX_POLLS(MAXP)) u_peer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(b_busy), .done(b_done), .error(b_err),
    .mm_address(b_adr), .mm_read(b_rd), .mm_write(b_wr), .mm_writedata(b_wd),
    .mm_byteenable(b_be), .mm_waitrequest(b_wt), .mm_readdata(b_rdd), .mm_readdatavalid(b_rv));
  bringup_slave_model #(.ADDR_W(ADDR_W), .OK_BIT(1)) u_sb (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ok_after(ok_after), .wait_n(wait_n), .ctl_init(ctl_init),
    .address(b_adr), .read(b_rd), .write(b_wr), .writedata(b_wd), .byteenable(b_be),
    .waitrequest(b_wt), .readdata(b_rdd), .readdatavalid(b_rv));

  ep_bringup_seq #(.ADDR_W(ADDR_W), .WIDE_ID(1'b1), .OWN_ID(16'h1234), .DEST_ID(16'hABCD),
                   .LINK_OK_BIT(1), .MAX_POLLS(MAXP)) u_wide (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(c_busy), .done(c_done), .error(c_err),
    .mm_address(c_adr), .mm_read(c_rd), .mm_write(c_wr), .mm_writedata(c_wd),
    .mm_byteenable(c_be), .mm_waitrequest(c_wt), .mm_readdata(c_rdd), .mm_readdatavalid(c_rv));
  bringup_slave_model #(.ADDR_W(ADDR_W), .OK_BIT(1)) u_sc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ok_after(ok_after), .wait_n(wait_n), .ctl_init(ctl_init),
    .address(c_adr), .read(c_rd), .write(c_wr), .writedata(c_wd), .byteenable(c_be),
    .waitrequest(c_wt), .readdata(c_rdd), .readdatavalid(c_rv));

  typedef struct packed {
    logic [7:0]  ok_after;
    logic [3:0]  wait_n;
    logic [31:0] ctl;
    logic        exp_err;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    '{8'd0, 4'd0, 32'h0000_0000, 1'b0},
    '{8'd3, 4'd2, 32'h0000_00A5, 1'b0},
    '{8'd5, 4'd1, 32'hFFFF_FFFF, 1'b0},
    '{8'd6, 4'd0, 32'h1234_5678, 1'b1},
    '{8'd1, 4'd3, 32'h8000_0001, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!a_busy && !b_busy && !c_busy) break;
    end
  endtask

  task automatic prep(input vec_t v);
    @(negedge clk);
    ok_after = v.ok_after; wait_n = v.wait_n; ctl_init = v.ctl; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic check_inst(input int idx, input vec_t v);
    int nw, ns, nc, fws, vio;
    logic dn, er, bz;
    logic [31:0] wa [4];
    logic [31:0] wd [4];
    logic [31:0] id_exp, win_exp;
    string nm;
    case (idx)
      0: begin nm = "A"; nw = u_sa.nw; ns = u_sa.n_stat; nc = u_sa.n_ctl; fws = u_sa.first_wr_stat;
         vio = u_sa.viol; dn = a_done; er = a_err; bz = a_busy;
         for (int k = 0; k < 4; k++) begin wa[k] = u_sa.wa[k]; wd[k] = u_sa.wd[k]; end
         id_exp = 32'h0001_0000; win_exp = 32'h0002_0000; end
      1: begin nm = "B"; nw = u_sb.nw; ns = u_sb.n_stat; nc = u_sb.n_ctl; fws = u_sb.first_wr_stat;
         vio = u_sb.viol; dn = b_done; er = b_err; bz = b_busy;
         for (int k = 0; k < 4; k++) begin wa[k] = u_sb.wa[k]; wd[k] = u_sb.wd[k]; end
         id_exp = 32'h0002_0000; win_exp = 32'h0000_0000; end
      default: begin nm = "C"; nw = u_sc.nw; ns = u_sc.n_stat; nc = u_sc.n_ctl; fws = u_sc.first_wr_stat;
         vio = u_sc.viol; dn = c_done; er = c_err; bz = c_busy;
         for (int k = 0; k < 4; k++) begin wa[k] = u_sc.wa[k]; wd[k] = u_sc.wd[k]; end
         id_exp = 32'h0000_1234; win_exp = 32'hABCD_0000; end
    endcase
    chk("R9", {nm, " bus hold/lane violations"}, 32'(vio), 0);
    chk("R11", {nm, " busy low at end"}, {31'b0, bz}, 0);
    if (v.exp_err) begin
      chk("R3", {nm, " error"}, {31'b0, er}, 1);
      chk("R3", {nm, " done"}, {31'b0, dn}, 0);
      chk("R3", {nm, " write count"}, 32'(nw), 0);
      chk("R3", {nm, " status reads"}, 32'(ns), MAXP);
    end else begin
      chk("R10", {nm, " done"}, {31'b0, dn}, 1);
      chk("R10", {nm, " error"}, {31'b0, er}, 0);
      chk("R2", {nm, " status reads"}, 32'(ns), 32'(v.ok_after) + 1);
      chk("R2", {nm, " reads before first write"}, 32'(fws), 32'(v.ok_after) + 1);
      chk("R8", {nm, " write count"}, 32'(nw), 4);
      chk("R8", {nm, " addr0"}, wa[0], 32'h60);
      chk("R8", {nm, " addr1"}, wa[1], 32'h13C);
      chk("R8", {nm, " addr2"}, wa[2], 32'h1010C);
      chk("R8", {nm, " addr3"}, wa[3], 32'h10104);
      chk("R4", {nm, " id word"}, wd[0], id_exp);
      chk("R5", {nm, " ctl reads"}, 32'(nc), 1);
      chk("R5", {nm, " ctl word"}, wd[1], v.ctl | 32'h4000_0000);
      chk("R6", {nm, " window word"}, wd[2], win_exp);
      chk("R7", {nm, " mask word"}, wd[3], 32'h0000_0004);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "idle flags", {29'b0, a_busy, a_done, a_err}, 0);
    chk("R1", "strobes", {26'b0, a_rd, a_wr, b_rd, b_wr, c_rd, c_wr}, 0);

    for (int r = 0; r < NVEC; r++) begin
      prep(VEC[r]);
      pulse_start();
      wait_idle();
      for (int i = 0; i < 3; i++) check_inst(i, VEC[r]);
      if (VEC[r].exp_err) begin
        repeat (10) @(negedge clk);
        chk("R3", "error held", {31'b0, a_err}, 1);
        chk("R3", "no late writes", 32'(u_sa.nw), 0);
      end
    end

    // R10: done held, cleared by next start
    prep(VEC[0]);
    pulse_start();
    wait_idle();
    repeat (30) @(negedge clk);
    chk("R10", "done held", {31'b0, a_done}, 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10", "done cleared by start", {31'b0, a_done}, 0);
    chk("R10", "busy after start", {31'b0, a_busy}, 1);
    wait_idle();

    // R10: start while busy is ignored
    prep('{8'd4, 4'd2, 32'h0000_0000, 1'b0});
    pulse_start();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (u_sa.nw >= 1) break;
    end
    pulse_start();
    wait_idle();
    chk("R10", "writes after busy start", 32'(u_sa.nw), 4);
    chk("R10", "status reads after busy start", 32'(u_sa.n_stat), 5);
    chk("R10", "done after busy start", {31'b0, a_done}, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule